// File: doc/BRIEF.md
# Two-Operand Arc-Tangent Front End (Special Values and Octant Steering)

This block sits at the head of a single-precision atan2(y, x) pipeline. It accepts two binary32 operands, y and x, qualified by a valid strobe, and after one register stage produces one of two things. For operand pairs whose answer is fixed by the floating-point special-value rules (NaN, infinities, signed zeros) or by equal magnitudes, it returns the final binary32 result directly and raises a special flag. For every other pair of finite, nonzero operands it returns a reduction descriptor instead.

The descriptor tells the downstream divider which quotient to form. The smaller magnitude is always the dividend, so the argument handed to the core arctangent never leaves [-1, 1]. It also names the constant offset (zero, ±pi/2 or ±pi) and says whether the core arctangent must be negated before the offset is added. The final angle is offset + (negate ? -1 : +1) * atan(quotient). The divider, the core evaluator and the final add belong to later stages.

Top module: `atan2_front`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block clears every output (out_valid, out_special, out_result, out_swap, out_offset, out_negate) to zero on that edge.
- R2: out_valid equals in_valid delayed by exactly one clock. All data outputs reflect the operands that were presented with in_valid high on the previous edge, and they hold their values unchanged after any edge at which in_valid is low.
- R3: If x is NaN (exponent all ones, fraction nonzero), the result is x with fraction bit 22 (the quiet bit) forced to 1. Otherwise, if y is NaN, the result is y with bit 22 forced to 1. The x test has priority.
- R4: For non-NaN operands with x = +infinity, the result is pi/4 (0x3F490FDB) when y is infinite and zero when y is finite. In both cases bit 31 is copied from y.
- R5: For non-NaN operands with x = -infinity, the result is 3pi/4 (0x4016CBE4) when y is infinite and pi (0x40490FDB) when y is finite. In both cases bit 31 is copied from y.
- R6: For finite x and infinite y, the result is pi/2 (0x3FC90FDB) with bit 31 copied from y.
- R7: For x = ±0 and y finite and nonzero, the result is pi/2 (0x3FC90FDB) with bit 31 copied from y.
- R8: For y = ±0 and finite x (zero included), the result is zero when x's sign bit is 0 and pi (0x40490FDB) when x's sign bit is 1. In both cases bit 31 is copied from y.
- R9: For finite, nonzero x and y with equal magnitudes (bits 30:0 equal), the result is pi/4 when x is positive and 3pi/4 when x is negative, with bit 31 copied from y.
- R10: For finite, nonzero operands with |y| < |x|, the descriptor is swap = 0 (quotient y/x) and negate = 0. The offset code is 0 (none) when x is positive. When x is negative it is 3 (+pi) for positive y and 4 (-pi) for negative y. Denormal operands count as finite and nonzero.
- R11: For finite, nonzero operands with |y| > |x|, the descriptor is swap = 1 (quotient x/y) and negate = 1. The offset code is 1 (+pi/2) for positive y and 2 (-pi/2) for negative y.
- R12: When out_special is 1, out_swap, out_offset and out_negate are all zero. When out_special is 0 with out_valid high, out_result is zero. In every non-special case, the descriptor reconstructs atan2(y, x) with a quotient magnitude of at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on in_y/in_x are valid this cycle |
| in_y | input | 32 | binary32 ordinate (first atan2 argument) |
| in_x | input | 32 | binary32 abscissa (second atan2 argument) |
| out_valid | output | 1 | Registered outputs are valid |
| out_special | output | 1 | out_result holds the final answer |
| out_result | output | 32 | Final binary32 result for special cases, zero otherwise |
| out_swap | output | 1 | 1: divide x by y; 0: divide y by x |
| out_offset | output | 3 | Offset code: 0 none, 1 +pi/2, 2 -pi/2, 3 +pi, 4 -pi |
| out_negate | output | 1 | Negate the core arctangent before adding the offset |

## Verification
The hardest cases to reach from the ports are the rule collisions, where one operand pair satisfies several special rules at once. Examples are x NaN with y NaN, x infinite with y zero, and x negative zero with y zero. In each of these only the priority order decides the answer. Random operands almost never produce these pairs, or the exact magnitude ties and denormal-against-normal comparisons, so directed tasks build them bit by bit. A random sweep then reconstructs the angle from the descriptor using a real-valued arctangent and compares it with a behavioural atan2.

// File: rtl/atan2_pkg.sv
// Shared constants and types for the atan2 front end.
// Assumes IEEE754 binary32 operands.
package atan2_pkg;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int OFS_W  = 3;

    // Magnitude encodings (sign bit clear) of the angle constants.
    localparam logic [WORD_W-1:0] K_PI      = 32'h40490FDB;
    localparam logic [WORD_W-1:0] K_HALF_PI = 32'h3FC90FDB;
    localparam logic [WORD_W-1:0] K_QTR_PI  = 32'h3F490FDB;
    localparam logic [WORD_W-1:0] K_3QTR_PI = 32'h4016CBE4;
    localparam logic [WORD_W-1:0] K_ZERO    = '0;

    // Constant offset added after the core arctangent.
    typedef enum logic [OFS_W-1:0] {
        OFS_NONE     = 3'd0,
        OFS_HALF_POS = 3'd1,
        OFS_HALF_NEG = 3'd2,
        OFS_FULL_POS = 3'd3,
        OFS_FULL_NEG = 3'd4
    } offset_e;

    // Operand classification.
    typedef struct packed {
        logic is_nan;
        logic is_inf;
        logic is_zero;
        logic neg;
    } op_class_t;
endpackage

// File: rtl/atan2_classify.sv
// Classifies one floating-point operand as NaN, infinity or zero, and
// extracts its sign. Denormals come out as finite and nonzero.
// Purely combinational.
module atan2_classify
    import atan2_pkg::*;
#(
    parameter int E_W = EXP_W,
    parameter int M_W = MAN_W
) (
    input  logic [E_W+M_W:0] op,
    output op_class_t        cls
);
    localparam logic [E_W-1:0] EXP_ONES = '1;

    logic [E_W-1:0] exp_f;
    logic [M_W-1:0] man_f;

    // Split the operand into fields and decode its class.
    always_comb begin
        exp_f       = op[E_W+M_W-1:M_W];
        man_f       = op[M_W-1:0];
        cls.is_nan  = (exp_f == EXP_ONES) && (man_f != '0);
        cls.is_inf  = (exp_f == EXP_ONES) && (man_f == '0);
        cls.is_zero = (op[E_W+M_W-1:0] == '0);
        cls.neg     = op[E_W+M_W];
    end
endmodule

// File: rtl/atan2_special.sv
// Resolves the fixed-answer cases of atan2(y, x), applying the rules in
// strict priority order: NaN propagation, infinite x, infinite y,
// zero x, zero y, then equal magnitudes. Assumes the operand classes
// come from atan2_classify. Purely combinational.
module atan2_special
    import atan2_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int M_W = MAN_W
) (
    input  logic [W-1:0] y,
    input  logic [W-1:0] x,
    input  op_class_t    cy,
    input  op_class_t    cx,
    output logic         hit,
    output logic [W-1:0] result
);
    logic [W-1:0] mag;
    logic         mag_eq;
    logic         y_fin_nz;

    // Choose the special answer; the sign is taken from y unless a NaN is propagated.
    always_comb begin
        hit      = 1'b1;
        mag      = K_ZERO;
        result   = K_ZERO;
        mag_eq   = (y[W-2:0] == x[W-2:0]);
        y_fin_nz = !cy.is_inf && !cy.is_zero;
        if (cx.is_nan) begin
            result          = x;
            result[M_W-1]   = 1'b1;
        end else if (cy.is_nan) begin
            result          = y;
            result[M_W-1]   = 1'b1;
        end else begin
            if (cx.is_inf && !cx.neg)
                mag = cy.is_inf ? K_QTR_PI : K_ZERO;
            else if (cx.is_inf && cx.neg)
                mag = cy.is_inf ? K_3QTR_PI : K_PI;
            else if (cy.is_inf)
                mag = K_HALF_PI;
            else if (cx.is_zero && y_fin_nz)
                mag = K_HALF_PI;
            else if (cy.is_zero)
                mag = cx.neg ? K_PI : K_ZERO;
            else if (mag_eq)
                mag = cx.neg ? K_3QTR_PI : K_QTR_PI;
            else
                hit = 1'b0;
            result = hit ? {cy.neg, mag[W-2:0]} : K_ZERO;
        end
    end
endmodule

// File: rtl/atan2_octant.sv
// Builds the reduction descriptor for finite, nonzero operands with
// unequal magnitudes. The larger magnitude is always the divisor, so the
// core argument stays inside [-1, 1]. For IEEE finite values the
// magnitude order equals the unsigned order of bits W-2:0. The output
// has no meaning for special operands; the top gates it off then.
module atan2_octant
    import atan2_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] y,
    input  logic [W-1:0] x,
    output logic         swap,
    output offset_e      offset,
    output logic         negate
);
    logic y_steep;

    // Pick the quotient orientation and the pi-multiple offset.
    always_comb begin
        y_steep = (y[W-2:0] > x[W-2:0]);
        if (y_steep) begin
            swap   = 1'b1;
            negate = 1'b1;
            offset = y[W-1] ? OFS_HALF_NEG : OFS_HALF_POS;
        end else begin
            swap   = 1'b0;
            negate = 1'b0;
            if (!x[W-1])
                offset = OFS_NONE;
            else
                offset = y[W-1] ? OFS_FULL_NEG : OFS_FULL_POS;
        end
    end
endmodule

// File: rtl/atan2_front.sv
// Front end of a binary32 atan2 unit: classifies both operands, resolves
// the special-value table, and otherwise emits a reduction descriptor.
// One register stage, synchronous active-low reset. Outputs hold while
// in_valid is low.
module atan2_front
    import atan2_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_y,
    input  logic [31:0] in_x,
    output logic        out_valid,
    output logic        out_special,
    output logic [31:0] out_result,
    output logic        out_swap,
    output logic [2:0]  out_offset,
    output logic        out_negate
);
    localparam int N_OPS = 2;

    logic [WORD_W-1:0] ops [N_OPS];
    op_class_t         cls [N_OPS];

    logic              sp_hit;
    logic [WORD_W-1:0] sp_result;
    logic              oc_swap;
    offset_e           oc_offset;
    logic              oc_negate;

    // Operand 0 is y, operand 1 is x.
    always_comb begin
        ops[0] = in_y;
        ops[1] = in_x;
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        atan2_classify #(.E_W(EXP_W), .M_W(MAN_W)) u_cls (
            .op  (ops[g]),
            .cls (cls[g])
        );
    end

    atan2_special #(.W(WORD_W), .M_W(MAN_W)) u_special (
        .y      (in_y),
        .x      (in_x),
        .cy     (cls[0]),
        .cx     (cls[1]),
        .hit    (sp_hit),
        .result (sp_result)
    );

    atan2_octant #(.W(WORD_W)) u_octant (
        .y      (in_y),
        .x      (in_x),
        .swap   (oc_swap),
        .offset (oc_offset),
        .negate (oc_negate)
    );

    // Output register: captures a new answer on each valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_special <= 1'b0;
            out_result  <= '0;
            out_swap    <= 1'b0;
            out_offset  <= OFS_NONE;
            out_negate  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_special <= sp_hit;
                out_result  <= sp_result;
                out_swap    <= sp_hit ? 1'b0 : oc_swap;
                out_offset  <= sp_hit ? OFS_NONE : oc_offset;
                out_negate  <= sp_hit ? 1'b0 : oc_negate;
            end
        end
    end

    // R2: valid is a one-cycle delay of the input strobe.
    a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: data holds across idle cycles.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_special) && $stable(out_offset)));
    // R3: a NaN abscissa yields a quiet NaN result.
    a_r3_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls[1].is_nan) |=> (out_special && out_result[22] && (out_result[30:23] == 8'hFF)));
    // R12: special results carry no descriptor.
    a_r12_desc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_special) |-> (!out_swap && (out_offset == 3'd0) && !out_negate));
    // R12: descriptors carry no result word.
    a_r12_result_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_special) |-> (out_result == 32'h0));
    // R11: a swapped quotient is always negated.
    a_r11_swap_negate: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_swap) |-> out_negate);
endmodule

// File: tb/atan2_front_tb.sv
module atan2_front_tb;
    localparam real CYC = 10.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_y = '0;
    logic [31:0] in_x = '0;
    logic        out_valid, out_special, out_swap, out_negate;
    logic [31:0] out_result;
    logic [2:0]  out_offset;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    localparam logic [31:0] PI   = 32'h40490FDB;
    localparam logic [31:0] HPI  = 32'h3FC90FDB;
    localparam logic [31:0] QPI  = 32'h3F490FDB;
    localparam logic [31:0] TQPI = 32'h4016CBE4;
    localparam logic [31:0] PINF = 32'h7F800000;
    localparam logic [31:0] NINF = 32'hFF800000;
    localparam logic [31:0] PZ   = 32'h00000000;
    localparam logic [31:0] NZ   = 32'h80000000;

    always #(CYC/2) clk = ~clk;

    atan2_front u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_y(in_y), .in_x(in_x),
        .out_valid(out_valid), .out_special(out_special), .out_result(out_result),
        .out_swap(out_swap), .out_offset(out_offset), .out_negate(out_negate)
    );

    function automatic real to_real(input logic [31:0] b);
        real m;
        int  e;
        e = int'(b[30:23]);
        if (e == 0) m = (real'(b[22:0]) / 8388608.0) * (2.0 ** (-126));
        else        m = (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** (e - 127));
        return b[31] ? -m : m;
    endfunction

    function automatic bit is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction
    function automatic bit is_inf(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] == 0);
    endfunction

    // Behavioural model built from the requirements.
    task automatic model(input logic [31:0] y, input logic [31:0] x,
                         output logic sp, output logic [31:0] res,
                         output logic sw, output logic [2:0] ofs, output logic ng);
        logic [31:0] m;
        sp = 1'b1; res = 0; sw = 0; ofs = 0; ng = 0; m = 0;
        if (is_nan(x))       res = x | 32'h0040_0000;
        else if (is_nan(y))  res = y | 32'h0040_0000;
        else begin
            if (is_inf(x))                          m = x[31] ? (is_inf(y) ? TQPI : PI) : (is_inf(y) ? QPI : PZ);
            else if (is_inf(y))                     m = HPI;
            else if (x[30:0] == 0 && y[30:0] != 0)  m = HPI;
            else if (y[30:0] == 0)                  m = x[31] ? PI : PZ;
            else if (x[30:0] == y[30:0])            m = x[31] ? TQPI : QPI;
            else sp = 1'b0;
            if (sp) res = {y[31], m[30:0]};
            else if (y[30:0] > x[30:0]) begin
                sw = 1; ng = 1; ofs = y[31] ? 3'd2 : 3'd1;
            end else
                ofs = !x[31] ? 3'd0 : (y[31] ? 3'd4 : 3'd3);
        end
    endtask

    task automatic fail_line(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_fail++;
        $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    endtask

    // Drive one operand pair, wait for the registered answer, compare with the model.
    task automatic apply(input logic [31:0] y, input logic [31:0] x, input string req);
        logic sp, sw, ng;
        logic [31:0] res;
        logic [2:0] ofs;
        real q, rec, ref_v, tol;
        @(negedge clk);
        in_valid = 1'b1; in_y = y; in_x = x;
        @(negedge clk);
        in_valid = 1'b0;
        model(y, x, sp, res, sw, ofs, ng);
        n_tests++;
        if (!out_valid || out_special !== sp || out_result !== res || out_swap !== sw
            || out_offset !== ofs || out_negate !== ng)
            fail_line(req, "outputs", {out_valid, out_special, out_swap, out_negate, 1'b0, out_offset, 16'h0, out_result},
                      {1'b1, sp, sw, ng, 1'b0, ofs, 16'h0, res});
        if (!sp) begin
            // R12: reconstruct the angle from the descriptor.
            n_tests++;
            q   = out_swap ? to_real(x) / to_real(y) : to_real(y) / to_real(x);
            rec = (out_negate ? -$atan(q) : $atan(q));
            case (out_offset)
                3'd1: rec += 1.5707963267948966;
                3'd2: rec -= 1.5707963267948966;
                3'd3: rec += 3.141592653589793;
                3'd4: rec -= 3.141592653589793;
                default: ;
            endcase
            ref_v = $atan2(to_real(y), to_real(x));
            tol = 1.0e-9;
            if (q > 1.0 || q < -1.0 || rec - ref_v > tol || ref_v - rec > tol) begin
                n_fail++;
                $display("FAIL R12 reconstruct: actual %f expected %f (q %f)", rec, ref_v, q);
            end
        end
    endtask

    task automatic t_reset();
        n_tests++;
        if (out_valid !== 0 || out_special !== 0 || out_result !== 0 || out_swap !== 0
            || out_offset !== 0 || out_negate !== 0)
            fail_line("R1", "reset", {out_valid, out_special, out_swap, out_negate, out_offset, out_result},
                      64'h0);
    endtask

    task automatic t_hold();
        logic [31:0] kept;
        apply(32'h3F800000, 32'hC0000000, "R2");
        kept = out_result;
        // Change inputs with in_valid low: nothing must move.
        in_y = PINF; in_x = PINF;
        @(negedge clk);
        @(negedge clk);
        n_tests++;
        if (out_valid !== 0 || out_result !== kept || out_special !== 0 || out_offset !== 3'd3)
            fail_line("R2", "hold", {out_valid, out_special, out_offset, out_result}, {2'b00, 3'd3, kept});
    endtask

    task automatic t_nan();
        apply(32'h3F800000, 32'h7F800001, "R3");
        apply(32'h7FC00005, 32'hFF812345, "R3");
        apply(32'hFF800010, 32'h40000000, "R3");
        apply(32'h7F800001, PINF, "R3");
    endtask

    task automatic t_xinf();
        apply(PINF, PINF, "R4");
        apply(NINF, PINF, "R4");
        apply(32'hC2000000, PINF, "R4");
        apply(NZ, PINF, "R4");
        apply(PINF, NINF, "R5");
        apply(NINF, NINF, "R5");
        apply(32'h40000000, NINF, "R5");
        apply(NZ, NINF, "R5");
    endtask

    task automatic t_yinf();
        apply(PINF, 32'h3F800000, "R6");
        apply(NINF, NZ, "R6");
        apply(NINF, 32'hC1000000, "R6");
    endtask

    task automatic t_xzero();
        apply(32'h3F800000, PZ, "R7");
        apply(32'hBF800000, NZ, "R7");
        apply(32'h00000001, NZ, "R7");
    endtask

    task automatic t_yzero();
        apply(PZ, PZ, "R8");
        apply(NZ, PZ, "R8");
        apply(PZ, NZ, "R8");
        apply(NZ, NZ, "R8");
        apply(NZ, 32'hC0400000, "R8");
        apply(PZ, 32'h00000003, "R8");
    endtask

    task automatic t_equal();
        apply(32'h40400000, 32'h40400000, "R9");
        apply(32'hC0400000, 32'h40400000, "R9");
        apply(32'h40400000, 32'hC0400000, "R9");
        apply(32'h80000007, 32'h80000007, "R9");
    endtask

    task automatic t_narrow();
        apply(32'h3F000000, 32'h40000000, "R10");
        apply(32'hBF000000, 32'h40000000, "R10");
        apply(32'h3F000000, 32'hC0000000, "R10");
        apply(32'hBF000000, 32'hC0000000, "R10");
        apply(32'h00000001, 32'h00000002, "R10");
        apply(32'h80000005, 32'hBF800000, "R10");
    endtask

    task automatic t_steep();
        apply(32'h40000000, 32'h3F000000, "R11");
        apply(32'hC0000000, 32'h3F000000, "R11");
        apply(32'h40000000, 32'hBF000000, "R11");
        apply(32'hC0000000, 32'hBF000000, "R11");
        apply(32'h00800000, 32'h807FFFFF, "R11");
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic t_random();
        logic [31:0] a, b;
        for (int i = 0; i < 300; i++) begin
            lfsr = step(lfsr); a = lfsr;
            lfsr = step(lfsr); b = lfsr;
            // Keep exponents moderate so the real quotient stays representable.
            a[30:23] = 8'd100 + {3'b0, a[27:23]} + {2'b0, a[29:24]};
            b[30:23] = 8'd100 + {3'b0, b[27:23]} + {2'b0, b[29:24]};
            apply(a, b, "R12");
        end
    endtask

    initial begin
        #(CYC * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_hold();
        t_nan();
        t_xinf();
        t_yinf();
        t_xzero();
        t_yzero();
        t_equal();
        t_narrow();
        t_steep();
        t_random();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule